// File: doc/BRIEF.md
# Battery charger enable supervisor

This block decides, cycle by cycle, whether a switching battery charger may run, and it sequences each start. It combines synchronous status flags from the analog front end with an active-high charge-enable pin. It also holds three host-programmed setpoints (charge voltage, charge current and input current limit) whose writes arrive as already-decoded strobes on a shared 16-bit data bus. The output is a converter-enable line, together with a 3-bit soft-start step index that ramps the current reference.

A start needs every enable condition to hold at once. Two start delays must also have run out. The first counts from adapter detection. The second counts from the moment the adapter is present and charge-enable is high. A host watchdog stops charging when the voltage and current setpoints have gone unwritten for too long. After it fires, charging stays off until both of those setpoints have been written again, in either order. Every start, including a restart after over-temperature clears, runs the full 8-step ramp from step 0.

All intervals are given in microseconds and scaled by a cycles-per-microsecond parameter. The defaults are 200 µs, 2 ms, 1.5 ms per step and 170 s.

Top module: `chg_enable_sup`

## Requirements
- R1: The converter is enabled only while adapter_ok_i, supply_ok_i, in_above_bat_i and rails_ok_i are all 1, chg_en_i is 1 and over_temp_i is 0. When any of these fails, conv_en_o is 0 from the next sample on, and ss_step_o reads 0 whenever conv_en_o is 0.
- R2: Enable first rises ADPT_DLY_US*CYC_PER_US+1 clock edges after adapter_ok_i is first sampled high, provided every other condition already holds and that delay is the longer of the two.
- R3: After chg_en_i rises while the adapter is already present and qualified, enable rises CE_DLY_US*CYC_PER_US+1 edges after chg_en_i is first sampled high. A low chg_en_i restarts this delay.
- R4: The charge-voltage setpoint (wr_vset_i, 1 mV per LSB, unsigned 16 bits) is valid only from 1024 to 19200 inclusive.
- R5: The charge-current setpoint (wr_iset_i, 1 mA per LSB) is valid only from 128 to 8064 inclusive. The input-limit setpoint (wr_ilim_i, 1 mA per LSB) is valid only from 256 to 11008 inclusive. All three registers reset to 0, which is invalid.
- R6: A write of an out-of-range value stops the converter on the cycle after the write edge. A later valid write to the same register restarts the converter 3 edges after that write is captured.
- R7: When WDOG_US*CYC_PER_US edges follow the last captured voltage or current write with no further such write, wdog_to_o goes to 1 and conv_en_o goes to 0 on the next edge. Writes to the input limit do not restart this count.
- R8: While wdog_to_o is 1, it stays 1 until a voltage write and a current write have both been captured since the timeout, in either order. It clears on the edge that captures the second of the two writes, and the converter restarts 4 edges after that write is captured.
- R9: Each start begins at step 0. The step index advances by one every SS_STEP_US*CYC_PER_US cycles up to 7 and then holds at 7 while running.
- R10: When over_temp_i returns to 0 with every other condition still holding, enable comes back 2 edges later with a fresh ramp from step 0.
- R11: During and after reset, conv_en_o=0, ss_step_o=0 and wdog_to_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adapter_ok_i | input | 1 | Adapter detected |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| in_above_bat_i | input | 1 | Input sufficiently above battery voltage |
| rails_ok_i | input | 1 | Internal regulators valid |
| over_temp_i | input | 1 | Thermal shutdown active (hysteresis applied upstream) |
| chg_en_i | input | 1 | Charge-enable pin, active high |
| wr_vset_i | input | 1 | Write strobe, charge-voltage setpoint |
| wr_iset_i | input | 1 | Write strobe, charge-current setpoint |
| wr_ilim_i | input | 1 | Write strobe, input-current-limit setpoint |
| wr_data_i | input | 16 | Value written by any strobe |
| conv_en_o | output | 1 | Converter enable |
| ss_step_o | output | 3 | Soft-start step index |
| wdog_to_o | output | 1 | Host watchdog timed out |

## Verification
A single voltage or current write does two jobs at once. It restarts the host watchdog, and it can stop the converter on the same edge by moving a setpoint out of range. The bench provokes this with out-of-range writes while the converter runs. It expects enable to fall one cycle later with no timeout status, and it expects the timeout to appear only a full window after the last voltage or current write. The second overlap comes while the watchdog has fired: the write that completes the pair both clears the timeout and starts the restart sequence. The bench checks that both happen, and that the restart comes exactly four edges after that write is captured.

// File: rtl/chg_sup_pkg.sv
package chg_sup_pkg;
  localparam int SP_W     = 16;
  localparam int N_SP     = 3;
  localparam int SP_VCHG  = 0;
  localparam int SP_ICHG  = 1;
  localparam int SP_ILIM  = 2;
  localparam int SS_STEPS = 8;
  localparam int STEP_W   = $clog2(SS_STEPS);

  typedef logic [SP_W-1:0] sp_t;

  localparam sp_t SP_MIN [N_SP] = '{16'd1024, 16'd128, 16'd256};
  localparam sp_t SP_MAX [N_SP] = '{16'd19200, 16'd8064, 16'd11008};

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SS   = 3'd2,
    ST_RUN  = 3'd3,
    ST_TMO  = 3'd4
  } sup_state_e;
endpackage

// File: rtl/chg_sup_setpoints.sv
module chg_sup_setpoints
  import chg_sup_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SP-1:0] wr_i,
  input  sp_t             data_i,
  output logic            all_ok_o
);
  logic [N_SP-1:0] in_range;

  for (genvar g = 0; g < N_SP; g++) begin : g_sp
    sp_t val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     val_q <= '0;
      else if (wr_i[g]) val_q <= data_i;
    end
    assign in_range[g] = (val_q >= SP_MIN[g]) && (val_q <= SP_MAX[g]);
  end

  assign all_ok_o = &in_range;
endmodule

// File: rtl/chg_sup_delay.sv
module chg_sup_delay #(
  parameter longint unsigned LIM = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic [CW-1:0] cnt_q;

  // saturating count of consecutive cycles with run_i high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM_C);
endmodule

// File: rtl/chg_sup_wdog.sv
module chg_sup_wdog #(
  parameter longint unsigned LIM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_v_i,
  input  logic kick_i_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIM);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;
  logic          seen_v_q, seen_i_q;
  logic          both_seen;

  assign both_seen = (seen_v_q | kick_v_i) & (seen_i_q | kick_i_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      exp_q    <= 1'b0;
      seen_v_q <= 1'b0;
      seen_i_q <= 1'b0;
    end else if (exp_q) begin
      if (both_seen) begin
        exp_q    <= 1'b0;
        cnt_q    <= '0;
        seen_v_q <= 1'b0;
        seen_i_q <= 1'b0;
      end else begin
        seen_v_q <= seen_v_q | kick_v_i;
        seen_i_q <= seen_i_q | kick_i_i;
      end
    end else if (kick_v_i || kick_i_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LIM_M1) begin
      exp_q    <= 1'b1;
      cnt_q    <= '0;
      seen_v_q <= 1'b0;
      seen_i_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/chg_sup_softstart.sv
module chg_sup_softstart
  import chg_sup_pkg::*;
#(
  parameter longint unsigned STEP_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  output logic [STEP_W-1:0] step_o,
  output logic              last_o
);
  localparam int CW = $clog2(STEP_CYC + 1);
  localparam logic [CW-1:0]     LAST_C = CW'(STEP_CYC - 1);
  localparam logic [STEP_W-1:0] TOP    = STEP_W'(SS_STEPS - 1);

  logic [CW-1:0]     cnt_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (!active_i) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (cnt_q == LAST_C) begin
      cnt_q <= '0;
      if (step_q != TOP) step_q <= step_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_o = step_q;
  assign last_o = active_i && (step_q == TOP) && (cnt_q == LAST_C);
endmodule

// File: rtl/chg_enable_sup.sv
module chg_enable_sup
  import chg_sup_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 125,
  parameter int unsigned ADPT_DLY_US = 200,
  parameter int unsigned CE_DLY_US   = 2000,
  parameter int unsigned SS_STEP_US  = 1500,
  parameter int unsigned WDOG_US     = 170_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adapter_ok_i,
  input  logic              supply_ok_i,
  input  logic              in_above_bat_i,
  input  logic              rails_ok_i,
  input  logic              over_temp_i,
  input  logic              chg_en_i,
  input  logic              wr_vset_i,
  input  logic              wr_iset_i,
  input  logic              wr_ilim_i,
  input  logic [SP_W-1:0]   wr_data_i,
  output logic              conv_en_o,
  output logic [STEP_W-1:0] ss_step_o,
  output logic              wdog_to_o
);
  localparam longint unsigned ADPT_CYC = 64'(CYC_PER_US) * 64'(ADPT_DLY_US);
  localparam longint unsigned CE_CYC   = 64'(CYC_PER_US) * 64'(CE_DLY_US);
  localparam longint unsigned SS_CYC   = 64'(CYC_PER_US) * 64'(SS_STEP_US);
  localparam longint unsigned WDOG_CYC = 64'(CYC_PER_US) * 64'(WDOG_US);

  sup_state_e        state_q, state_d;
  logic              sp_ok, adp_done, ce_done, expired;
  logic              ok_all, run_st, ss_last;
  logic [STEP_W-1:0] ss_step;
  logic [N_SP-1:0]   wr_vec;

  always_comb begin
    wr_vec          = '0;
    wr_vec[SP_VCHG] = wr_vset_i;
    wr_vec[SP_ICHG] = wr_iset_i;
    wr_vec[SP_ILIM] = wr_ilim_i;
  end

  chg_sup_setpoints u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_vec),
    .data_i   (wr_data_i),
    .all_ok_o (sp_ok)
  );

  chg_sup_delay #(.LIM(ADPT_CYC)) u_adp_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (adapter_ok_i),
    .done_o (adp_done)
  );

  chg_sup_delay #(.LIM(CE_CYC)) u_ce_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (adapter_ok_i & chg_en_i),
    .done_o (ce_done)
  );

  chg_sup_wdog #(.LIM(WDOG_CYC)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_v_i  (wr_vset_i),
    .kick_i_i  (wr_iset_i),
    .expired_o (expired)
  );

  assign run_st = (state_q == ST_SS) || (state_q == ST_RUN);

  chg_sup_softstart #(.STEP_CYC(SS_CYC)) u_ss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (run_st),
    .step_o   (ss_step),
    .last_o   (ss_last)
  );

  assign ok_all = adapter_ok_i & supply_ok_i & in_above_bat_i & rails_ok_i &
                  chg_en_i & ~over_temp_i & sp_ok & ~expired;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ok_all) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!ok_all)                state_d = ST_IDLE;
        else if (adp_done && ce_done) state_d = ST_SS;
      end
      ST_SS: begin
        if (!ok_all)      state_d = ST_IDLE;
        else if (ss_last) state_d = ST_RUN;
      end
      ST_RUN:  if (!ok_all) state_d = ST_IDLE;
      ST_TMO:  if (!expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (expired && state_q != ST_TMO) state_d = ST_TMO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // gating by ok_all stops the converter without waiting for the FSM edge
  assign conv_en_o = run_st & ok_all;
  assign ss_step_o = conv_en_o ? ss_step : '0;
  assign wdog_to_o = expired;
endmodule

// File: rtl/chg_sup_chk.sv
module chg_sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       adapter_ok_i,
  input logic       supply_ok_i,
  input logic       in_above_bat_i,
  input logic       rails_ok_i,
  input logic       over_temp_i,
  input logic       chg_en_i,
  input logic       wr_vset_i,
  input logic       wr_iset_i,
  input logic       conv_en_o,
  input logic [2:0] ss_step_o,
  input logic       wdog_to_o
);
  // R1
  en_needs_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_o |-> (adapter_ok_i && supply_ok_i && in_above_bat_i && rails_ok_i &&
                   chg_en_i && !over_temp_i));

  // R1
  idle_step_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_en_o |-> (ss_step_o == 3'd0));

  // R3
  start_after_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> ($past(adapter_ok_i) && $past(chg_en_i)));

  // R9
  start_step_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_en_o) |-> (ss_step_o == 3'd0));

  // R9
  step_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_en_o && $past(conv_en_o)) |->
      ((ss_step_o == $past(ss_step_o)) || (ss_step_o == $past(ss_step_o) + 3'd1)));

  // R7
  timeout_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_to_o |-> !conv_en_o);

  // R8
  timeout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_to_o && !wr_vset_i && !wr_iset_i) |=> wdog_to_o);
endmodule

bind chg_enable_sup chg_sup_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .adapter_ok_i   (adapter_ok_i),
  .supply_ok_i    (supply_ok_i),
  .in_above_bat_i (in_above_bat_i),
  .rails_ok_i     (rails_ok_i),
  .over_temp_i    (over_temp_i),
  .chg_en_i       (chg_en_i),
  .wr_vset_i      (wr_vset_i),
  .wr_iset_i      (wr_iset_i),
  .conv_en_o      (conv_en_o),
  .ss_step_o      (ss_step_o),
  .wdog_to_o      (wdog_to_o)
);

// File: tb/chg_enable_sup_tb.sv
module chg_enable_sup_tb;
  // scaled timing: adapter delay 60, enable delay 40, step 8, watchdog 1000 cycles
  localparam int SS = 8;
  localparam int WD = 1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adapter_ok = 1'b0, supply_ok = 1'b1, in_above_bat = 1'b1;
  logic        rails_ok = 1'b1, over_temp = 1'b0, chg_en = 1'b1;
  logic        wr_vset = 1'b0, wr_iset = 1'b0, wr_ilim = 1'b0;
  logic [15:0] wr_data = '0;
  logic        conv_en, wdog_to;
  logic [2:0]  ss_step;

  always #4 clk = ~clk;

  chg_enable_sup #(
    .CYC_PER_US(2), .ADPT_DLY_US(30), .CE_DLY_US(20), .SS_STEP_US(4), .WDOG_US(500)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .adapter_ok_i(adapter_ok), .supply_ok_i(supply_ok),
    .in_above_bat_i(in_above_bat), .rails_ok_i(rails_ok), .over_temp_i(over_temp),
    .chg_en_i(chg_en), .wr_vset_i(wr_vset), .wr_iset_i(wr_iset), .wr_ilim_i(wr_ilim),
    .wr_data_i(wr_data), .conv_en_o(conv_en), .ss_step_o(ss_step), .wdog_to_o(wdog_to)
  );

  typedef struct {
    int       cyc;
    logic     en;
    logic [2:0] step;
    logic     to;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   mon_cyc = 0;
  int   base = 0;
  int   total = 0;
  int   bad = 0;

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      mon_cyc++;
      while (q.size() > 0 && q[0].cyc <= mon_cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (e.cyc < mon_cyc) begin
          bad++;
          $display("FAIL %s: sample slot %0d missed (now %0d), expected en=%0b step=%0d to=%0b",
                   e.tag, e.cyc, mon_cyc, e.en, e.step, e.to);
        end else if (conv_en !== e.en || ss_step !== e.step || wdog_to !== e.to) begin
          bad++;
          $display("FAIL %s @%0d: en=%0b step=%0d to=%0b expected en=%0b step=%0d to=%0b",
                   e.tag, mon_cyc, conv_en, ss_step, wdog_to, e.en, e.step, e.to);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic start_scn();
    @(negedge clk);
    base = mon_cyc;
  endtask

  task automatic expect_at(int off, logic en, logic [2:0] step, logic to, string tag);
    exp_t e;
    e.cyc = base + off; e.en = en; e.step = step; e.to = to; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  // called right after a negedge: strobe held for one cycle
  task automatic wr_pulse(int sel, int val);
    wr_data = 16'(val);
    wr_vset = (sel == 0);
    wr_iset = (sel == 1);
    wr_ilim = (sel == 2);
    @(negedge clk);
    wr_vset = 1'b0; wr_iset = 1'b0; wr_ilim = 1'b0;
  endtask

  function automatic int dflt(int sel);
    return (sel == 0) ? 16800 : (sel == 1) ? 2048 : 4096;
  endfunction

  task automatic kick();
    @(negedge clk);
    wr_pulse(0, 16800);
  endtask

  task automatic sp_case(int sel, int val, bit keep, string tag);
    start_scn();
    expect_at(1, keep, keep ? 3'd7 : 3'd0, 1'b0, tag);
    expect_at(2, keep, keep ? 3'd7 : 3'd0, 1'b0, tag);
    wr_pulse(sel, val);
    drain();
    if (!keep) begin
      // R6 restart after valid rewrite
      start_scn();
      expect_at(2, 1'b0, 3'd0, 1'b0, {tag, " R6 restore"});
      expect_at(3, 1'b1, 3'd0, 1'b0, {tag, " R6 restore"});
      wr_pulse(sel, dflt(sel));
      drain();
      repeat (70) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    start_scn();
    expect_at(1, 1'b0, 3'd0, 1'b0, "R11");
    expect_at(4, 1'b0, 3'd0, 1'b0, "R11");
    drain();

    @(negedge clk); wr_pulse(0, 16800);
    wr_pulse(1, 2048);
    wr_pulse(2, 4096);

    // R2 adapter delay governs, R9 full ramp
    start_scn();
    adapter_ok = 1'b1;
    expect_at(60, 1'b0, 3'd0, 1'b0, "R2 before delay");
    expect_at(61, 1'b1, 3'd0, 1'b0, "R2 start");
    for (int k = 0; k < 8; k++) expect_at(61 + k * SS, 1'b1, 3'(k), 1'b0, "R9 step");
    expect_at(61 + 8 * SS + 5, 1'b1, 3'd7, 1'b0, "R9 hold");
    drain();

    // R1 enable pin low, R3 enable delay restarts
    kick();
    start_scn();
    chg_en = 1'b0;
    expect_at(1, 1'b0, 3'd0, 1'b0, "R1 ce low");
    drain();
    start_scn();
    chg_en = 1'b1;
    expect_at(40, 1'b0, 3'd0, 1'b0, "R3 before delay");
    expect_at(41, 1'b1, 3'd0, 1'b0, "R3 start");
    drain();

    // R1 adapter removal and input-above-battery flag
    kick();
    start_scn();
    adapter_ok = 1'b0;
    expect_at(1, 1'b0, 3'd0, 1'b0, "R1 adapter removed");
    drain();
    start_scn();
    in_above_bat = 1'b0;
    adapter_ok = 1'b1;
    expect_at(70, 1'b0, 3'd0, 1'b0, "R1 input flag low");
    drain();
    start_scn();
    in_above_bat = 1'b1;
    expect_at(1, 1'b0, 3'd0, 1'b0, "R1 flag back");
    expect_at(2, 1'b1, 3'd0, 1'b0, "R1 flag back");
    drain();

    // R10 thermal shutdown and fresh ramp
    kick();
    start_scn();
    over_temp = 1'b1;
    expect_at(1, 1'b0, 3'd0, 1'b0, "R10 hot");
    drain();
    repeat (10) @(negedge clk);
    start_scn();
    over_temp = 1'b0;
    expect_at(1, 1'b0, 3'd0, 1'b0, "R10 cooled");
    expect_at(2, 1'b1, 3'd0, 1'b0, "R10 restart");
    expect_at(2 + SS, 1'b1, 3'd1, 1'b0, "R10 ramp");
    drain();
    repeat (80) @(negedge clk);

    // R4 voltage window
    sp_case(0, 19200, 1'b1, "R4 max");
    sp_case(0, 1024,  1'b1, "R4 min");
    sp_case(0, 1023,  1'b0, "R4 below");
    sp_case(0, 19201, 1'b0, "R4 above");
    // R5 current windows
    sp_case(1, 8064,  1'b1, "R5 ichg max");
    sp_case(1, 8065,  1'b0, "R5 ichg above");
    sp_case(1, 127,   1'b0, "R5 ichg below");
    sp_case(1, 128,   1'b1, "R5 ichg min");
    kick();
    sp_case(2, 11008, 1'b1, "R5 ilim max");
    sp_case(2, 11009, 1'b0, "R5 ilim above");
    sp_case(2, 255,   1'b0, "R5 ilim below");
    sp_case(2, 256,   1'b1, "R5 ilim min");

    // R7 watchdog: a current write restarts the window
    start_scn();
    wr_pulse(0, 16800);
    repeat (300) @(negedge clk);
    start_scn();
    expect_at(WD, 1'b1, 3'd7, 1'b0, "R7 before expiry");
    expect_at(WD + 1, 1'b0, 3'd0, 1'b1, "R7 expiry");
    wr_pulse(1, 2048);
    drain();

    // R8 both setpoints needed
    start_scn();
    expect_at(1, 1'b0, 3'd0, 1'b1, "R8 voltage only");
    expect_at(20, 1'b0, 3'd0, 1'b1, "R8 voltage only");
    wr_pulse(0, 16800);
    drain();
    start_scn();
    expect_at(1, 1'b0, 3'd0, 1'b0, "R8 cleared");
    expect_at(3, 1'b0, 3'd0, 1'b0, "R8 restart pending");
    expect_at(4, 1'b1, 3'd0, 1'b0, "R8 restart");
    wr_pulse(1, 2048);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule